// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps 32-bit addresses from a local bus into a 64-bit PCIe address space. A fixed set of windows is chosen at elaboration time. Each window has a base address, an inclusive high address, a 64-bit translation value and a flag that selects a 64-bit or a 32-bit target space. On every valid request the block compares the address against all windows in parallel. It reports whether a window matched and which one matched, and it returns the translated address.

For a matching window, the offset bits spanned by the window size come straight from the input address. The bits above the offset come from the translation value. Any translation-value bits that fall inside the offset field are ignored. A request that matches no window is reported as a miss, with a zero address. The result is registered, so it appears one clock after the request, with a valid strobe alongside it.

Each window size must be a power of two, and its base must be aligned to that size. When windows overlap, the window with the lowest index wins. Up to 16 windows are supported.

Top module: `owin_xlate`

## Requirements
- R1: After reset, rsp_valid, rsp_hit, rsp_miss, rsp_win and rsp_addr are all zero. rsp_valid equals req_valid from exactly one clock earlier.
- R2: A valid request whose address satisfies base <= addr <= high for some window gives rsp_hit=1 and rsp_miss=0 one cycle later. rsp_win then holds that window's index, where the index is the position of the window in the parameter arrays, counting from 0. Both edges of the window count as inside.
- R3: For a hit on a window of size S = high - base + 1, bits [log2(S)-1:0] of rsp_addr equal the same bits of req_addr. The upper bits equal the translation value with its low log2(S) bits cleared, so translation bits inside the offset field have no effect.
- R4: With the default parameters, the results are as follows. 0x12340ABC gives 0x5000000056710ABC on window 0. 0xABCDF123 gives 0x60000000FEDC1123 on window 1. 0xFFFEDCBA gives 0x7000000041FEDCBA on window 2.
- R5: When the space flag of the matching window is 1, all 64 bits are translated. When the flag is 0, rsp_addr[63:32] is zero.
- R6: A valid request that matches no window gives rsp_miss=1, rsp_hit=0, rsp_win=0 and rsp_addr=0 one cycle later.
- R7: When an address lies in more than one window, the lowest-indexed matching window supplies rsp_win and rsp_addr.
- R8: A cycle with req_valid=0 gives rsp_valid=0, rsp_hit=0, rsp_miss=0, rsp_win=0 and rsp_addr=0 on the next cycle, whatever req_addr holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Local-bus address to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after req_valid |
| rsp_hit | output | 1 | Address fell inside a window |
| rsp_miss | output | 1 | Valid request matched no window |
| rsp_win | output | 4 | Index of the matching window |
| rsp_addr | output | 64 | Translated address, zero on a miss |

## Verification
The hardest cases to reach from the ports are overlap priority and the narrow target space. The default windows are disjoint, and all of them are wide. To reach these cases, the bench drives a second instance whose two windows overlap. The lower-indexed window in that instance has its space flag cleared, and its translation value has junk in the offset bits. Shared addresses show which window wins, and they also show that the junk bits and the upper half are dropped. Edge addresses at base, high, base-1 and high+1 of every window are driven directly. Random traffic, biased into the large window, fills in the rest, and every cycle is compared against an arithmetic model.

// File: rtl/owin_pkg.sv
package owin_pkg;

    localparam int ADDR_IN_W  = 32;
    localparam int ADDR_OUT_W = 64;
    localparam int IDX_W      = 4;

    typedef logic [ADDR_IN_W-1:0]  in_addr_t;
    typedef logic [ADDR_OUT_W-1:0] out_addr_t;
    typedef logic [IDX_W-1:0]      win_idx_t;

    typedef struct packed {
        logic      hit;
        win_idx_t  idx;
        out_addr_t addr;
    } xres_t;

    // Offset mask of an aligned power-of-two window
    function automatic in_addr_t span_mask(in_addr_t base, in_addr_t high);
        return high - base;
    endfunction

    function automatic logic in_window(in_addr_t a, in_addr_t base, in_addr_t high);
        return (a >= base) && (a <= high);
    endfunction

    // Keep offset bits from the input, take the rest from the translation value
    function automatic out_addr_t splice(in_addr_t a, in_addr_t mask,
                                         out_addr_t xlat, logic wide);
        out_addr_t m64;
        out_addr_t r;
        m64 = {{(ADDR_OUT_W-ADDR_IN_W){1'b0}}, mask};
        r   = (xlat & ~m64) | ({{(ADDR_OUT_W-ADDR_IN_W){1'b0}}, a} & m64);
        if (!wide)
            r[ADDR_OUT_W-1:ADDR_IN_W] = '0;
        return r;
    endfunction

endpackage

// File: rtl/owin_match.sv
module owin_match
    import owin_pkg::*;
#(
    parameter in_addr_t  BASE = '0,
    parameter in_addr_t  HIGH = '1,
    parameter out_addr_t XLAT = '0,
    parameter logic      WIDE = 1'b1
) (
    input  in_addr_t  addr,
    output logic      hit,
    output out_addr_t xaddr
);
    localparam in_addr_t MASK = span_mask(BASE, HIGH);

    always_comb begin
        hit   = in_window(addr, BASE, HIGH);
        xaddr = splice(addr, MASK, XLAT, WIDE);
    end
endmodule

// File: rtl/owin_select.sv
module owin_select
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 3
) (
    input  logic [NUM_WIN-1:0]                 hits,
    input  logic [NUM_WIN-1:0][ADDR_OUT_W-1:0] cand,
    output xres_t                              res
);
    // Walk from the top down so the lowest matching index is written last
    always_comb begin
        res = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                res.hit  = 1'b1;
                res.idx  = IDX_W'(i);
                res.addr = cand[i];
            end
        end
    end
endmodule

// File: rtl/owin_outreg.sv
module owin_outreg
    import owin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  xres_t     in_res,
    output logic      rsp_valid,
    output logic      rsp_hit,
    output logic      rsp_miss,
    output win_idx_t  rsp_win,
    output out_addr_t rsp_addr
);
    logic take;
    assign take = in_valid && in_res.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_win   <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= in_valid;
            rsp_hit   <= take;
            rsp_miss  <= in_valid && !in_res.hit;
            rsp_win   <= take ? in_res.idx  : '0;
            rsp_addr  <= take ? in_res.addr : '0;
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> rsp_valid);

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_addr == '0 && rsp_win == '0));

    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_addr == '0 && rsp_win == '0));
endmodule

// File: rtl/owin_xlate.sv
module owin_xlate
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter logic [NUM_WIN-1:0][ADDR_IN_W-1:0]  WIN_BASE =
        {32'hFE00_0000, 32'hABCD_E000, 32'h1234_0000},
    parameter logic [NUM_WIN-1:0][ADDR_IN_W-1:0]  WIN_HIGH =
        {32'hFFFF_FFFF, 32'hABCD_FFFF, 32'h1234_FFFF},
    parameter logic [NUM_WIN-1:0][ADDR_OUT_W-1:0] WIN_XLAT =
        {64'h7000_0000_4000_0000, 64'h6000_0000_FEDC_0000, 64'h5000_0000_5671_0000},
    parameter logic [NUM_WIN-1:0]                 WIN_WIDE = '1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_miss,
    output logic [3:0]  rsp_win,
    output logic [63:0] rsp_addr
);
    logic [NUM_WIN-1:0]                 hit_vec;
    logic [NUM_WIN-1:0][ADDR_OUT_W-1:0] cand;
    xres_t                              sel;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        owin_match #(
            .BASE (WIN_BASE[g]),
            .HIGH (WIN_HIGH[g]),
            .XLAT (WIN_XLAT[g]),
            .WIDE (WIN_WIDE[g])
        ) u_match (
            .addr  (req_addr),
            .hit   (hit_vec[g]),
            .xaddr (cand[g])
        );
    end

    owin_select #(.NUM_WIN(NUM_WIN)) u_select (
        .hits (hit_vec),
        .cand (cand),
        .res  (sel)
    );

    owin_outreg u_outreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_res    (sel),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_win   (rsp_win),
        .rsp_addr  (rsp_addr)
    );

    // Checker helpers: per-index lookup of the window parameters
    function automatic in_addr_t mask_of(win_idx_t w);
        in_addr_t m = '0;
        for (int i = 0; i < NUM_WIN; i++)
            if (w == IDX_W'(i)) m = span_mask(WIN_BASE[i], WIN_HIGH[i]);
        return m;
    endfunction

    function automatic logic inside_of(win_idx_t w, in_addr_t a);
        logic r = 1'b0;
        for (int i = 0; i < NUM_WIN; i++)
            if (w == IDX_W'(i)) r = in_window(a, WIN_BASE[i], WIN_HIGH[i]);
        return r;
    endfunction

    function automatic logic wide_of(win_idx_t w);
        logic r = 1'b0;
        for (int i = 0; i < NUM_WIN; i++)
            if (w == IDX_W'(i)) r = WIN_WIDE[i];
        return r;
    endfunction

    p_hit_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit_vec != '0) |=> rsp_hit);

    p_hit_inside_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> inside_of(rsp_win, $past(req_addr)));

    p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (((rsp_addr[31:0] ^ $past(req_addr)) & mask_of(rsp_win)) == '0));

    p_narrow_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && !wide_of(rsp_win)) |-> (rsp_addr[63:32] == '0));

    p_lowest_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit_vec[0]) |=> (rsp_win == '0));
endmodule

// File: tb/owin_xlate_bench.sv
`timescale 1ns/1ps
module owin_xlate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;

    logic        v0, h0, m0, v1, h1, m1;
    logic [3:0]  w0, w1;
    logic [63:0] a0, a1;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2 clk = ~clk;

    owin_xlate u_owin_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(v0), .rsp_hit(h0), .rsp_miss(m0), .rsp_win(w0), .rsp_addr(a0)
    );

    // Second configuration: overlapping windows, window 0 narrow with junk offset bits
    owin_xlate #(
        .NUM_WIN  (2),
        .WIN_BASE ({32'h0000_0000, 32'h0000_1000}),
        .WIN_HIGH ({32'h0000_FFFF, 32'h0000_1FFF}),
        .WIN_XLAT ({64'h1111_2222_3333_5555, 64'hFFFF_FFFF_AAAA_0FFF}),
        .WIN_WIDE (2'b10)
    ) u_owin_xlate_ovl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(v1), .rsp_hit(h1), .rsp_miss(m1), .rsp_win(w1), .rsp_addr(a1)
    );

    // Behavioural model: arithmetic on window sizes, first match wins
    function automatic void model(input int cfg, input logic [31:0] a,
                                  output bit hit, output int idx, output logic [63:0] o);
        longint unsigned base [3];
        longint unsigned high [3];
        longint unsigned xl   [3];
        bit              wide [3];
        int              n;
        if (cfg == 0) begin
            n = 3;
            base = '{64'h1234_0000, 64'hABCD_E000, 64'hFE00_0000};
            high = '{64'h1234_FFFF, 64'hABCD_FFFF, 64'hFFFF_FFFF};
            xl   = '{64'h5000_0000_5671_0000, 64'h6000_0000_FEDC_0000, 64'h7000_0000_4000_0000};
            wide = '{1, 1, 1};
        end else begin
            n = 2;
            base = '{64'h1000, 64'h0, 64'h0};
            high = '{64'h1FFF, 64'hFFFF, 64'h0};
            xl   = '{64'hFFFF_FFFF_AAAA_0FFF, 64'h1111_2222_3333_5555, 64'h0};
            wide = '{0, 1, 0};
        end
        hit = 0; idx = 0; o = '0;
        for (int i = 0; i < n; i++) begin
            if (!hit && a >= base[i] && a <= high[i]) begin
                longint unsigned size = high[i] - base[i] + 1;
                hit = 1;
                idx = i;
                o   = (xl[i] / size) * size + (longint'(a) - base[i]);
                if (!wide[i]) o = o & 64'hFFFF_FFFF;
            end
        end
    endfunction

    // Expected values for the outputs visible at the next sample
    bit          ev;
    bit          eh [2];
    int          ew [2];
    logic [63:0] ea [2];
    string       etag;

    task automatic cmp(input string inst, input string tag,
                       input logic v, input logic h, input logic m,
                       input logic [3:0] w, input logic [63:0] a,
                       input bit xv, input bit xh, input int xw, input logic [63:0] xa);
        bit xm = xv && !xh;
        vectors++;
        if (v !== xv || h !== xh || m !== xm || int'(w) != xw || a !== xa) begin
            miscompares++;
            $display("FAIL %s %s: v/h/m/win/addr act %b/%b/%b/%0d/%h exp %b/%b/%b/%0d/%h",
                     tag, inst, v, h, m, w, a, xv, xh, xm, xw, xa);
        end
    endtask

    task automatic step(input logic [31:0] addr, input bit valid, input string tag);
        @(negedge clk);
        cmp("main", etag, v0, h0, m0, w0, a0, ev, eh[0], ew[0], ea[0]);
        cmp("ovl",  etag, v1, h1, m1, w1, a1, ev, eh[1], ew[1], ea[1]);
        req_valid = valid;
        req_addr  = addr;
        etag = tag;
        ev = valid;
        for (int c = 0; c < 2; c++) begin
            bit hh; int ii; logic [63:0] oo;
            model(c, addr, hh, ii, oo);
            eh[c] = valid && hh;
            ew[c] = (valid && hh) ? ii : 0;
            ea[c] = (valid && hh) ? oo : '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: act expired exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        ev = 0; eh = '{0, 0}; ew = '{0, 0}; ea = '{64'h0, 64'h0}; etag = "R1";
        repeat (3) @(posedge clk);
        // R1: reset state, checked while reset is held
        @(negedge clk);
        cmp("main", "R1", v0, h0, m0, w0, a0, 0, 0, 0, '0);
        cmp("ovl",  "R1", v1, h1, m1, w1, a1, 0, 0, 0, '0);
        rst = 1'b0;
        // R4: default-window examples
        step(32'h1234_0ABC, 1, "R4");
        step(32'hABCD_F123, 1, "R4");
        step(32'hFFFE_DCBA, 1, "R4");
        // R2 edges inside, R6 edges just outside
        step(32'h1234_0000, 1, "R2");
        step(32'h1234_FFFF, 1, "R2");
        step(32'h1233_FFFF, 1, "R6");
        step(32'h1235_0000, 1, "R6");
        step(32'hABCD_E000, 1, "R2");
        step(32'hABCD_FFFF, 1, "R2");
        step(32'hABCD_DFFF, 1, "R6");
        step(32'hABCE_0000, 1, "R6");
        step(32'hFE00_0000, 1, "R2");
        step(32'hFFFF_FFFF, 1, "R2");
        step(32'hFDFF_FFFF, 1, "R6");
        step(32'h0001_0000, 1, "R6");
        // R8: idle cycle with an address that would hit
        step(32'h1234_0ABC, 0, "R8");
        step(32'h0000_1234, 0, "R8");
        // R7 overlap priority, R3 junk offset bits in translation ignored
        step(32'h0000_1234, 1, "R7");
        step(32'h0000_1000, 1, "R7");
        step(32'h0000_1FFF, 1, "R3");
        // R5 wide and narrow spaces
        step(32'h0000_2345, 1, "R5");
        step(32'h0000_FFFF, 1, "R5");
        step(32'h0000_0000, 1, "R5");
        // R1: alternating strobe
        for (int k = 0; k < 8; k++) step(32'h1234_0010 + k, k[0], "R1");
        // Random traffic biased toward windows
        for (int k = 0; k < 600; k++) begin
            logic [31:0] a;
            int pick = $urandom % 5;
            case (pick)
                0: a = 32'hFE00_0000 | ($urandom & 32'h01FF_FFFF);
                1: a = 32'h1234_0000 | ($urandom & 32'h0001_FFFF) - 32'h0000_8000;
                2: a = $urandom & 32'h0000_3FFF;
                3: a = 32'hABCD_C000 | ($urandom & 32'h0000_7FFF);
                default: a = $urandom;
            endcase
            step(a, ($urandom % 4) != 0, "R2");
        end
        step(32'h0, 0, "R8");
        step(32'h0, 0, "R8");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule